// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block chooses which of two reference clocks drives a downstream clock-synthesis loop. Both references are sampled as plain signals in the system clock domain. Each one passes through a synchronizer and then an activity monitor. The monitor flags the input as lost when no rising edge arrives within a timeout. It flags the input as healthy again after a run of good edge periods.

A 2-bit mode field sets the selection policy. Two of the four policies are manual: one follows an external pin and the other follows a register bit. The other two are automatic, and in both of them the register bit names the primary input. In non-revertive failover the block stays on the backup input once it has moved there. In revertive failover it returns to the primary input as soon as the primary is healthy. The block registers the selected index and emits a one-cycle event pulse whenever that index changes. The actual clock multiplexer lives outside this block.

Top module: `ref_clock_selector`

## Requirements
- R1: With mode 2'b00 the selection follows the synchronized select pin (0 = input 0, 1 = input 1). The register bit and the loss flags have no effect.
- R2: With mode 2'b11 the selection follows the register bit (0 = input 0, 1 = input 1). The pin and the loss flags have no effect.
- R3: An input's loss flag (bit i of `lost` for input i) rises once TIMEOUT system cycles pass with no rising edge seen on that input.
- R4: A lost input's flag clears only after GOOD_EDGES consecutive rising edges, each within TIMEOUT cycles of the previous one.
- R5: With mode 2'b01 (non-revertive), the block moves to the other input when the selected input is lost and the other input is healthy.
- R6: With mode 2'b01, the block stays on the backup input after the primary recovers. It changes only when the current input is lost.
- R7: With mode 2'b10 (revertive), the block selects the primary input named by the register bit whenever that input is healthy. Otherwise it selects the other input if that input is healthy.
- R8: In either automatic mode, when both inputs are lost the selection holds its value and both loss flags read 1.
- R9: `switch_evt` is high for exactly one cycle, the cycle in which `sel_idx` takes a new value, and is low otherwise.
- R10: After reset `sel_idx` = 0, `lost` = 2'b00 and `switch_evt` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | Reference clock activity, one bit per input |
| pin_sel | input | 1 | External select pin (asynchronous) |
| reg_sel | input | 1 | Register select bit: manual choice, or the primary input in automatic modes |
| mode | input | 2 | Selection policy: 00 pin, 01 auto non-revertive, 10 auto revertive, 11 register |
| sel_idx | output | 1 | Selected input index |
| lost | output | 2 | Per-input loss flags |
| switch_evt | output | 1 | One-cycle pulse on each selection change |

## Verification
The stimulus sequence exercises the difference between the automatic modes. The primary input fails and then comes back under the non-revertive policy, and again under the revertive policy. A design that mixed up the two policies would return too early or never return. Both inputs are stopped together under the revertive policy. A design without the both-lost hold would bounce to a dead input and emit extra switch pulses, which the per-step pulse count catches. The manual modes run with the unused select source set to the opposite value and, in one step, with a dead input selected, so a design that leaked the wrong source or let loss override a manual choice shows a wrong index. Loss and recovery timing are checked against windows around TIMEOUT and GOOD_EDGES, which exposes an off-by-many counter.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SEL_PIN      = 2'b00,
    SEL_AUTO_NR  = 2'b01,
    SEL_AUTO_REV = 2'b10,
    SEL_REG      = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refsel_monitor.sv
module refsel_monitor #(
  parameter int TIMEOUT    = 16,
  parameter int GOOD_EDGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic lost
);
  localparam int CNT_W  = $clog2(TIMEOUT);
  localparam int GOOD_W = $clog2(GOOD_EDGES + 1);

  logic              prev;
  logic              edge_seen;
  logic [CNT_W-1:0]  idle_cnt;
  logic [GOOD_W-1:0] good_cnt;

  assign edge_seen = level & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= 1'b0;
      idle_cnt <= '0;
      good_cnt <= '0;
      lost     <= 1'b0;
    end else begin
      prev <= level;
      if (edge_seen) begin
        idle_cnt <= '0;
        if (lost) begin
          if (good_cnt == GOOD_W'(GOOD_EDGES - 1)) begin
            lost     <= 1'b0;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end
      end else if (idle_cnt == CNT_W'(TIMEOUT - 1)) begin
        idle_cnt <= '0;
        lost     <= 1'b1;
        good_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R3: a loss is declared only at the end of a full idle window
  p_loss_at_timeout_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> ($past(idle_cnt) == CNT_W'(TIMEOUT - 1) && !$past(edge_seen)));

  // R4: recovery only happens on an observed edge
  p_recover_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(lost) |-> $past(edge_seen));
endmodule

// File: rtl/refsel_policy.sv
module refsel_policy
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       pin_s,
  input  logic       reg_sel,
  input  logic [1:0] lost,
  output logic       sel,
  output logic       evt
);
  logic sel_nxt;
  logic other;

  assign other = ~sel;

  always_comb begin
    sel_nxt = sel;
    case (sel_mode_e'(mode))
      SEL_PIN:     sel_nxt = pin_s;
      SEL_REG:     sel_nxt = reg_sel;
      SEL_AUTO_NR: begin
        if (lost[sel] && !lost[other]) sel_nxt = other;
      end
      default: begin
        if (!lost[reg_sel])      sel_nxt = reg_sel;
        else if (!lost[~reg_sel]) sel_nxt = ~reg_sel;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= 1'b0;
      evt <= 1'b0;
    end else begin
      sel <= sel_nxt;
      evt <= (sel_nxt != sel);
    end
  end

  p_pin_manual_r1: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> sel == $past(pin_s));

  p_reg_manual_r2: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> sel == $past(reg_sel));

  p_nonrevert_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !lost[sel]) |=> $stable(sel));

  p_both_lost_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mode[1] != mode[0] && lost == 2'b11) |=> $stable(sel));

  p_event_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    evt |-> sel != $past(sel));

  p_change_has_event_r9: assert property (@(posedge clk) disable iff (rst)
    !evt |-> $stable(sel));
endmodule

// File: rtl/ref_clock_selector.sv
module ref_clock_selector #(
  parameter int TIMEOUT     = 16,
  parameter int GOOD_EDGES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_in,
  input  logic       pin_sel,
  input  logic       reg_sel,
  input  logic [1:0] mode,
  output logic       sel_idx,
  output logic [1:0] lost,
  output logic       switch_evt
);
  localparam int NUM_REFS = 2;

  logic [NUM_REFS-1:0] ref_s;
  logic                pin_s;

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    refsel_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d(ref_in[i]), .q(ref_s[i])
    );
    refsel_monitor #(.TIMEOUT(TIMEOUT), .GOOD_EDGES(GOOD_EDGES)) i_mon (
      .clk(clk), .rst(rst), .level(ref_s[i]), .lost(lost[i])
    );
  end

  refsel_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk(clk), .rst(rst), .d(pin_sel), .q(pin_s)
  );

  refsel_policy i_policy (
    .clk(clk), .rst(rst), .mode(mode), .pin_s(pin_s), .reg_sel(reg_sel),
    .lost(lost), .sel(sel_idx), .evt(switch_evt)
  );

  // R10: quiet outputs in the cycle after reset
  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> (sel_idx == 1'b0 && lost == 2'b00 && !switch_evt));
endmodule

// File: tb/test_ref_clock_selector.sv
`timescale 1ns/1ps
module test_ref_clock_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_in;
  logic       pin_sel = 1'b0;
  logic       reg_sel = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       sel_idx;
  logic [1:0] lost;
  logic       switch_evt;
  logic [1:0] en = 2'b11;
  int         ph = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  // shared phase: both references toggle every 3 cycles, period 6
  always @(negedge clk) ph <= (ph == 5) ? 0 : ph + 1;
  assign ref_in = en & {2{ph < 3}};

  ref_clock_selector i_ref_clock_selector (
    .clk(clk), .rst(rst), .ref_in(ref_in), .pin_sel(pin_sel), .reg_sel(reg_sel),
    .mode(mode), .sel_idx(sel_idx), .lost(lost), .switch_evt(switch_evt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {mode[1:0], reg_sel, pin_sel, en0, en1, exp_sel, exp_lost0, exp_lost1}
  localparam logic [8:0] VEC [16] = '{
    9'b00_0_1_11_1_00,  // R1 pin 1, reg 0
    9'b00_1_0_11_0_00,  // R1 pin 0, reg 1 ignored
    9'b11_1_0_11_1_00,  // R2 reg 1
    9'b11_0_1_11_0_00,  // R2 reg 0, pin ignored
    9'b01_0_0_11_0_00,  // R6 auto nonrev stays
    9'b01_0_0_01_1_10,  // R5 fail over
    9'b01_0_0_11_1_00,  // R6 stays on backup
    9'b10_0_0_11_0_00,  // R7 revert to primary
    9'b10_0_0_01_1_10,  // R7 fail over
    9'b10_0_0_11_0_00,  // R7 return
    9'b10_0_0_00_0_11,  // R8 both lost hold
    9'b10_0_0_01_1_10,  // R7 backup recovers
    9'b10_1_0_11_1_00,  // R7 primary is input 1
    9'b01_1_0_11_1_00,  // R6 nonrev
    9'b01_1_0_10_0_01,  // R5 fail over to 0
    9'b11_1_0_10_1_01   // R2 manual ignores loss
  };

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic prev_sel;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sel_idx == 1'b0 && lost == 2'b00 && !switch_evt, "R10 reset", {sel_idx, lost, switch_evt}, 0);
    prev_sel = 1'b0;
    for (int v = 0; v < 16; v++) begin
      int pulses;
      logic [8:0] e;
      e = VEC[v];
      mode = e[8:7]; reg_sel = e[6]; pin_sel = e[5]; en = {e[3], e[4]};
      pulses = 0;
      repeat (80) begin
        @(negedge clk);
        if (switch_evt) pulses++;
      end
      check(sel_idx == e[2], $sformatf("R1/R2/R5/R6/R7 sel step %0d", v), sel_idx, e[2]);
      check(lost == {e[0], e[1]}, $sformatf("R3/R4/R8 lost step %0d", v), lost, {e[0], e[1]});
      check(pulses == int'(e[2] != prev_sel), $sformatf("R9 pulses step %0d", v), pulses, int'(e[2] != prev_sel));
      prev_sel = e[2];
    end

    // R10: reset again restores the quiet state
    rst = 1'b1; en = 2'b11; mode = 2'b11; reg_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sel_idx == 1'b0 && lost == 2'b00 && !switch_evt, "R10 second reset", {sel_idx, lost, switch_evt}, 0);
    repeat (30) @(negedge clk);

    // R3: loss timing window around TIMEOUT
    en = 2'b10;
    repeat (8) @(negedge clk);
    check(lost[0] == 1'b0, "R3 not lost early", lost[0], 0);
    repeat (14) @(negedge clk);
    check(lost[0] == 1'b1, "R3 lost after timeout", lost[0], 1);

    // R4: recovery needs several edges
    en = 2'b11;
    repeat (8) @(negedge clk);
    check(lost[0] == 1'b1, "R4 still lost after one edge", lost[0], 1);
    repeat (32) @(negedge clk);
    check(lost[0] == 1'b0, "R4 recovered", lost[0], 0);
    check(sel_idx == 1'b0, "R2 manual kept through loss", sel_idx, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule